// File: doc/BRIEF.md
# Signed-Count Arithmetic Shift Unit

This block performs the arithmetic shifts of a 16-bit minicomputer datapath. It has two operations. The word operation shifts one 16-bit register. The pair operation shifts a 32-bit value built from two registers. A 6-bit two's-complement count field chooses the direction and the distance: a positive count shifts left, a negative count shifts right with sign fill, and zero passes the operand through. Along with the result, the block returns the four condition codes: negative, zero, overflow and carry.

The caller supplies the operation, the operand words and the raw count field, then pulses `start`. One clock later the result and the condition codes appear on registered outputs with `done` high. The outputs hold their values until the next `start`. For the pair operation, `src_hi` holds the register named by the instruction and `src_lo` holds its odd partner. When the named register is itself odd, the caller raises `pair_odd`. The block then forms the 32-bit operand from that one register repeated in both halves, and returns only the low half of the result, on both result ports.

Top module: `ashift_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `done`, `res_hi`, `res_lo` and all four flags are cleared to zero.
- R2: `done` is high exactly in the cycle after a cycle in which `start` was high. When `start` is low, the result ports and the flag ports keep their values.
- R3: `shift_field` is read as a signed value from -32 to +31. Positive values shift left and negative values shift right arithmetically. A value of 0 returns the operand unchanged and clears `flag_c`.
- R4: Word operation (`op`=0) with a count from 1 to 15: `res_hi` is `src_hi` shifted left by the count, and `flag_c` is bit (16 - count) of `src_hi`.
- R5: Word operation with a count from 16 to 31: `res_hi` is 0. `flag_c` is 1 only when the count is 16 and bit 0 of `src_hi` is 1.
- R6: Word operation with a count from -1 to -15: `res_hi` is `src_hi` shifted right with sign fill, and `flag_c` is bit (|count| - 1). For counts from -16 to -32, every bit of `res_hi` equals bit 15 of `src_hi`, and `flag_c` is bit 15.
- R7: `flag_n` is the result's top bit and `flag_z` is 1 when the result is all zeros. `flag_v` is 1 when the result's top bit differs from the operand's top bit. The top bit is bit 15 for the word operation and bit 31 for the pair operation.
- R8: Pair operation (`op`=1, `pair_odd`=0): the operand is {`src_hi`,`src_lo`}. `res_hi` returns result bits 31:16 and `res_lo` returns bits 15:0. A left shift sets `flag_c` to the last bit that left bit 31. A right shift sets it to the last bit that left bit 0.
- R9: Pair operation with a count of -32: all 32 result bits equal operand bit 31, and `flag_c` equals operand bit 31.
- R10: Pair operation with `pair_odd`=1: the operand is {`src_hi`,`src_hi`}. Both `res_hi` and `res_lo` carry result bits 15:0, and the flags come from the full 32-bit result.
- R11: Word operation: `res_lo` returns `src_lo` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Accept the operands this cycle |
| op | input | 1 | 0 = word shift, 1 = pair shift |
| pair_odd | input | 1 | Pair operation names an odd register |
| src_hi | input | 16 | Word operand, or high half of the pair |
| src_lo | input | 16 | Low half of the pair; returned unchanged for the word operation |
| shift_field | input | 6 | Signed shift count |
| done | output | 1 | Result valid |
| res_hi | output | 16 | Word result, or high half of the pair result |
| res_lo | output | 16 | Low half of the pair result, or `src_lo` for the word operation |
| flag_n | output | 1 | Negative |
| flag_z | output | 1 | Zero |
| flag_v | output | 1 | Sign changed |
| flag_c | output | 1 | Last bit shifted out |

## Verification
The bound checker checks these properties on every cycle:
- the one-cycle handshake and the holding of outputs while idle;
- the negative, zero and overflow flags against the visible result for the word operation and the even pair;
- the pass-through of the low word in the word operation;
- the equal halves of an odd pair;
- the zero-count identity.

Some behaviour depends on the exact shift amount, so only the bench's scenarios can show it. The bench covers the shifted values and the carry bit at every count from -32 to +31, the zero result and the carry rule at and beyond the width, the sign fill at -32, and the flags of an odd pair, whose high result half is never visible. It also checks the reset state and a reset applied in the middle of a run.

// File: rtl/ashift_pkg.sv
// Shared definitions for the arithmetic shift unit.
// Assumes: op encoding 0 = word, 1 = register pair.
package ashift_pkg;
    typedef enum logic {
        SH_WORD = 1'b0,
        SH_PAIR = 1'b1
    } shift_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } ccode_t;
endpackage

// File: rtl/shift_count_decode.sv
// Turns the raw signed count field into a direction and a magnitude.
// Assumes: field is two's complement; the magnitude needs one bit more
// than the field so that the most negative count fits.
module shift_count_decode #(
    parameter int CW = 6
) (
    input  logic [CW-1:0] field,
    output logic          go_left,
    output logic          go_right,
    output logic [CW:0]   mag
);
    logic signed [CW:0] sx;

    // sign-extend the field and take its absolute value
    always_comb begin
        sx       = {field[CW-1], field};
        go_left  = (sx > 0);
        go_right = (sx < 0);
        mag      = go_right ? $unsigned(-sx) : $unsigned(sx);
    end
endmodule

// File: rtl/arith_shifter.sv
// Width-generic arithmetic shifter. One extra guard bit catches the last
// bit shifted out in either direction.
// Assumes: mag may exceed W; a left shift then yields zero and a right
// shift yields all sign bits. The carry falls out of the guard bit.
module arith_shifter #(
    parameter int W  = 16,
    parameter int MW = 7
) (
    input  logic [W-1:0]  x,
    input  logic          go_left,
    input  logic          go_right,
    input  logic [MW-1:0] mag,
    output logic [W-1:0]  y,
    output logic          c_out
);
    logic        [W:0] lt;
    logic signed [W:0] rt;

    // shift with a zero guard above (left) or below (right) the operand
    always_comb begin
        lt = {1'b0, x} << mag;
        rt = $signed({x, 1'b0}) >>> mag;
        if (go_left) begin
            y     = lt[W-1:0];
            c_out = lt[W];
        end else if (go_right) begin
            y     = rt[W:1];
            c_out = rt[0];
        end else begin
            y     = x;
            c_out = 1'b0;
        end
    end
endmodule

// File: rtl/ccode_gen.sv
// Condition-code generator for a shift result of width W.
// Assumes: the carry comes from the shifter; V means the sign changed.
module ccode_gen
    import ashift_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] opnd,
    input  logic [W-1:0] res,
    input  logic         c_in,
    output ccode_t       cc
);
    // derive N, Z, V from result and operand, pass C through
    always_comb begin
        cc.n = res[W-1];
        cc.z = (res == '0);
        cc.v = res[W-1] ^ opnd[W-1];
        cc.c = c_in;
    end
endmodule

// File: rtl/ashift_unit.sv
// Top of the arithmetic shift unit: single-word and register-pair shifts
// with a signed count, and registered results and condition codes.
// Assumes: inputs are steady around the rising edge on which start is high;
// results appear one cycle later and hold until the next start.
module ashift_unit
    import ashift_pkg::*;
#(
    parameter int WW = 16,
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          op,
    input  logic          pair_odd,
    input  logic [WW-1:0] src_hi,
    input  logic [WW-1:0] src_lo,
    input  logic [CW-1:0] shift_field,
    output logic          done,
    output logic [WW-1:0] res_hi,
    output logic [WW-1:0] res_lo,
    output logic          flag_n,
    output logic          flag_z,
    output logic          flag_v,
    output logic          flag_c
);
    localparam int DW = 2 * WW;
    localparam int MW = CW + 1;

    logic          go_left, go_right;
    logic [MW-1:0] mag;
    logic [WW-1:0] w_res;
    logic          w_c;
    logic [DW-1:0] p_opnd, p_res;
    logic          p_c;
    ccode_t        w_cc, p_cc, sel_cc;
    logic [WW-1:0] nxt_hi, nxt_lo;

    shift_count_decode #(.CW(CW)) u_dec (
        .field(shift_field), .go_left(go_left), .go_right(go_right), .mag(mag)
    );

    arith_shifter #(.W(WW), .MW(MW)) u_word (
        .x(src_hi), .go_left(go_left), .go_right(go_right), .mag(mag),
        .y(w_res), .c_out(w_c)
    );

    // build the pair operand; an odd register supplies both halves
    always_comb p_opnd = pair_odd ? {src_hi, src_hi} : {src_hi, src_lo};

    arith_shifter #(.W(DW), .MW(MW)) u_pair (
        .x(p_opnd), .go_left(go_left), .go_right(go_right), .mag(mag),
        .y(p_res), .c_out(p_c)
    );

    ccode_gen #(.W(WW)) u_wcc (.opnd(src_hi), .res(w_res), .c_in(w_c), .cc(w_cc));
    ccode_gen #(.W(DW)) u_pcc (.opnd(p_opnd), .res(p_res), .c_in(p_c), .cc(p_cc));

    // pick the result words and codes for the selected operation
    always_comb begin
        if (shift_op_e'(op) == SH_WORD) begin
            nxt_hi = w_res;
            nxt_lo = src_lo;
            sel_cc = w_cc;
        end else begin
            nxt_hi = pair_odd ? p_res[WW-1:0] : p_res[DW-1:WW];
            nxt_lo = p_res[WW-1:0];
            sel_cc = p_cc;
        end
    end

    // register the outputs; load on start, otherwise hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done   <= 1'b0;
            res_hi <= '0;
            res_lo <= '0;
            flag_n <= 1'b0;
            flag_z <= 1'b0;
            flag_v <= 1'b0;
            flag_c <= 1'b0;
        end else begin
            done <= start;
            if (start) begin
                res_hi <= nxt_hi;
                res_lo <= nxt_lo;
                flag_n <= sel_cc.n;
                flag_z <= sel_cc.z;
                flag_v <= sel_cc.v;
                flag_c <= sel_cc.c;
            end
        end
    end
endmodule

// File: rtl/ashift_unit_chk.sv
// Checker for ashift_unit, attached with bind below.
// Assumes: done implies start one cycle earlier, so $past of the inputs
// gives the operands of the result on display.
module ashift_unit_chk #(
    parameter int WW = 16,
    parameter int CW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          op,
    input logic          pair_odd,
    input logic [WW-1:0] src_hi,
    input logic [WW-1:0] src_lo,
    input logic [CW-1:0] shift_field,
    input logic          done,
    input logic [WW-1:0] res_hi,
    input logic [WW-1:0] res_lo,
    input logic          flag_n,
    input logic          flag_z,
    input logic          flag_v,
    input logic          flag_c
);
    assert_done_follows_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);
    assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);
    assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(res_hi) && $stable(res_lo) && $stable(flag_n)
                    && $stable(flag_z) && $stable(flag_v) && $stable(flag_c)));
    assert_zero_count_identity_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !$past(op) && $past(shift_field) == '0)
        |-> (res_hi == $past(src_hi) && !flag_c));
    assert_word_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !$past(op))
        |-> (flag_n == res_hi[WW-1] && flag_z == (res_hi == '0)
             && flag_v == (res_hi[WW-1] ^ $past(src_hi[WW-1]))));
    assert_pair_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(op) && !$past(pair_odd))
        |-> (flag_n == res_hi[WW-1] && flag_z == ({res_hi, res_lo} == '0)
             && flag_v == (res_hi[WW-1] ^ $past(src_hi[WW-1]))));
    assert_odd_pair_halves_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(op) && $past(pair_odd)) |-> (res_hi == res_lo));
    assert_word_low_pass_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !$past(op)) |-> (res_lo == $past(src_lo)));
endmodule

bind ashift_unit ashift_unit_chk #(.WW(WW), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .pair_odd(pair_odd),
    .src_hi(src_hi), .src_lo(src_lo), .shift_field(shift_field), .done(done),
    .res_hi(res_hi), .res_lo(res_lo), .flag_n(flag_n), .flag_z(flag_z),
    .flag_v(flag_v), .flag_c(flag_c)
);

// File: tb/ashift_unit_bench.sv
// Self-checking bench: a table of directed vectors, then a sweep of every
// count for both operations, then directed tests for reset and holding.
module ashift_unit_bench;
    localparam time TCLK = 20ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op = 1'b0;
    logic        pair_odd = 1'b0;
    logic [15:0] src_hi = '0;
    logic [15:0] src_lo = '0;
    logic [5:0]  shift_field = '0;
    logic        done;
    logic [15:0] res_hi, res_lo;
    logic        flag_n, flag_z, flag_v, flag_c;

    int n_checks = 0;
    int n_fail = 0;
    logic [31:0] rng = 32'h1234_5678;

    always #(TCLK / 2) clk = ~clk;

    ashift_unit u_ashift_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .pair_odd(pair_odd),
        .src_hi(src_hi), .src_lo(src_lo), .shift_field(shift_field), .done(done),
        .res_hi(res_hi), .res_lo(res_lo), .flag_n(flag_n), .flag_z(flag_z),
        .flag_v(flag_v), .flag_c(flag_c)
    );

    // vector: op, odd, hi, lo, field, exp_hi, exp_lo, exp {n,z,v,c}
    typedef struct packed {
        logic        op;
        logic        odd;
        logic [15:0] hi;
        logic [15:0] lo;
        logic [5:0]  f;
        logic [15:0] ehi;
        logic [15:0] elo;
        logic [3:0]  ecc;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 16'h0001, 16'h1234, 6'h01, 16'h0002, 16'h1234, 4'b0000}, // R4
        '{1'b0, 1'b0, 16'h8001, 16'h0000, 6'h10, 16'h0000, 16'h0000, 4'b0111}, // R5
        '{1'b0, 1'b0, 16'h8000, 16'hAAAA, 6'h3F, 16'hC000, 16'hAAAA, 4'b1000}, // R6
        '{1'b0, 1'b0, 16'h4000, 16'h0000, 6'h01, 16'h8000, 16'h0000, 4'b1010}, // R7
        '{1'b0, 1'b0, 16'h0003, 16'h0000, 6'h3E, 16'h0000, 16'h0000, 4'b0101}, // R6
        '{1'b0, 1'b0, 16'h8000, 16'h5555, 6'h20, 16'hFFFF, 16'h5555, 4'b1001}, // R6
        '{1'b0, 1'b0, 16'h1234, 16'h0F0F, 6'h00, 16'h1234, 16'h0F0F, 4'b0000}, // R3
        '{1'b1, 1'b0, 16'h0000, 16'h8000, 6'h01, 16'h0001, 16'h0000, 4'b0000}, // R8
        '{1'b1, 1'b0, 16'h8000, 16'h0000, 6'h20, 16'hFFFF, 16'hFFFF, 4'b1001}, // R9
        '{1'b1, 1'b0, 16'h0000, 16'h0001, 6'h3F, 16'h0000, 16'h0000, 4'b0101}, // R8
        '{1'b1, 1'b1, 16'h0001, 16'hDEAD, 6'h04, 16'h0010, 16'h0010, 4'b0000}, // R10
        '{1'b0, 1'b0, 16'h0001, 16'h0000, 6'h11, 16'h0000, 16'h0000, 4'b0100}, // R5
        '{1'b0, 1'b0, 16'hFFFF, 16'h0000, 6'h0F, 16'h8000, 16'h0000, 4'b1001}  // R4
    };

    // independent model: integer multiply and divide-style shifts
    function automatic logic [35:0] model(input logic o, input logic od,
                                          input logic [15:0] h, input logic [15:0] l,
                                          input logic [5:0] f);
        int          cnt;
        int          w;
        longint      v, p;
        logic [31:0] r;
        logic        cy;
        logic [15:0] oh, ol;
        logic        nn, zz, vv;
        cnt = int'($signed(f));
        if (!o) begin
            w = 16;
            v = longint'($signed(h));
        end else begin
            w = 32;
            v = longint'($signed(od ? {h, h} : {h, l}));
        end
        if (cnt > 0) begin
            p  = v * (longint'(1) << cnt);
            r  = p[31:0];
            cy = p[w];
        end else if (cnt < 0) begin
            p  = v >>> (-cnt);
            r  = p[31:0];
            p  = v >>> (-cnt - 1);
            cy = p[0];
        end else begin
            r  = v[31:0];
            cy = 1'b0;
        end
        if (w == 16) begin
            nn = r[15];
            zz = (r[15:0] == 16'h0);
            vv = r[15] ^ v[15];
            oh = r[15:0];
            ol = l;
        end else begin
            nn = r[31];
            zz = (r == 32'h0);
            vv = r[31] ^ v[31];
            oh = od ? r[15:0] : r[31:16];
            ol = r[15:0];
        end
        return {oh, ol, nn, zz, vv, cy};
    endfunction

    function automatic string tag_of(input logic o, input logic od, input logic [5:0] f);
        int cnt;
        cnt = int'($signed(f));
        if (!o) begin
            if (cnt == 0) return "R3";
            if (cnt > 15) return "R5";
            if (cnt > 0) return "R4";
            return "R6";
        end
        if (od) return "R10";
        if (cnt == -32) return "R9";
        return "R8";
    endfunction

    function automatic logic [31:0] next_rng(input logic [31:0] s);
        logic [31:0] t;
        t = s ^ (s << 13);
        t = t ^ (t >> 17);
        return t ^ (t << 5);
    endfunction

    task automatic check(input string tag, input logic [36:0] got, input logic [36:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s (flags R7, low word R11): got done/hi/lo/nzvc=%h expected %h",
                     tag, got, exp);
        end
    endtask

    // drive one operation, sample the registered result one cycle later
    task automatic apply(input logic o, input logic od, input logic [15:0] h,
                         input logic [15:0] l, input logic [5:0] f,
                         input logic [35:0] exp, input string tag);
        @(negedge clk);
        op = o; pair_odd = od; src_hi = h; src_lo = l; shift_field = f; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(tag, {done, res_hi, res_lo, flag_n, flag_z, flag_v, flag_c}, {1'b1, exp});
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(TCLK * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got hung run, expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", {done, res_hi, res_lo, flag_n, flag_z, flag_v, flag_c}, 37'h0);
        rst_n = 1'b1;

        // table of directed vectors, cross-checked against the model too
        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].op, VECS[i].odd, VECS[i].hi, VECS[i].lo, VECS[i].f,
                  {VECS[i].ehi, VECS[i].elo, VECS[i].ecc},
                  tag_of(VECS[i].op, VECS[i].odd, VECS[i].f));
            check("model-vs-table", {1'b1, model(VECS[i].op, VECS[i].odd, VECS[i].hi,
                  VECS[i].lo, VECS[i].f)},
                  {1'b1, VECS[i].ehi, VECS[i].elo, VECS[i].ecc});
        end

        // sweep every count, both operations and odd pairs, edge and random operands
        for (int cs = -32; cs < 32; cs++) begin
            for (int k = 0; k < 7; k++) begin
                logic [15:0] h, l;
                case (k)
                    0: begin h = 16'h0000; l = 16'h0000; end
                    1: begin h = 16'hFFFF; l = 16'hFFFF; end
                    2: begin h = 16'h8000; l = 16'h0000; end
                    default: begin
                        rng = next_rng(rng);
                        h = rng[15:0];
                        l = rng[31:16];
                    end
                endcase
                for (int m = 0; m < 3; m++) begin
                    logic o, od;
                    logic [5:0] f;
                    o  = (m != 0);
                    od = (m == 2);
                    f  = 6'(cs);
                    apply(o, od, h, l, f, model(o, od, h, l, f), tag_of(o, od, f));
                end
            end
        end

        // R2: outputs hold and done drops while start stays low
        apply(1'b0, 1'b0, 16'h00F0, 16'h1111, 6'h02,
              model(1'b0, 1'b0, 16'h00F0, 16'h1111, 6'h02), "R4");
        @(negedge clk);
        src_hi = 16'hFFFF; src_lo = 16'h0; shift_field = 6'h20; op = 1'b1;
        @(negedge clk);
        check("R2", {done, res_hi, res_lo, flag_n, flag_z, flag_v, flag_c},
              {1'b0, model(1'b0, 1'b0, 16'h00F0, 16'h1111, 6'h02)});

        // R1: reset in the middle of a run clears everything
        apply(1'b1, 1'b0, 16'hFFFF, 16'hFFFF, 6'h3F,
              model(1'b1, 1'b0, 16'hFFFF, 16'hFFFF, 6'h3F), "R8");
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", {done, res_hi, res_lo, flag_n, flag_z, flag_v, flag_c}, 37'h0);
        rst_n = 1'b1;

        finish_run();
    end
endmodule